// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out the counted-loop branch step of a 16-bit core: it adjusts one register by minus one, zero or plus one, writes the new value back, and then decides whether to branch. The branch is taken when the new value is zero, or when it is nonzero, as the instruction selects. All of the control comes packed into one postbyte: the kind of step, the branch sense, the sign of the offset and the register to use. A separate offset byte carries the low eight bits of the branch displacement.

The core's decode stage pulses `start_i`. On the same cycle it presents the postbyte, the offset byte and the program counter as it stands after operand fetch. The block drives the register-file read select from the postbyte and reads the operand combinationally. On the next clock edge it registers the write-back request, the next program counter, the branch decision and an error flag. It marks them with a one-cycle `done_o` strobe. The register file and instruction fetch sit outside the block.

Top module: `loop_branch_unit`

## Requirements
- R1: With postbyte bits 7:6 = 00 the selected register is decremented by one and the result is written back.
- R2: With postbyte bits 7:6 = 01 the register value is written back unchanged; only the branch test is applied.
- R3: With postbyte bits 7:6 = 10 the selected register is incremented by one and the result is written back.
- R4: Postbyte bits 7:6 = 11 is illegal. In that case `illegal_o` is 1, `wr_en_o` is 0, `taken_o` is 0 and `pc_next_o` equals the incoming PC, all with `done_o`.
- R5: The branch target is the incoming PC plus a 9-bit signed offset. Postbyte bit 4 is the sign bit and the offset byte supplies the low eight bits, so bit 4 = 1 extends the byte with ones through bit 15. The sum wraps modulo 2^16.
- R6: Postbyte bit 5 = 1 branches when the updated value is nonzero. Bit 5 = 0 branches when the updated value is zero.
- R7: Register select is postbyte bits 2:0, driven on `rd_sel_o` and `wr_sel_o`. Selects 0 to 3 are 8-bit registers. For them the step and the zero test use only bits 7:0 of `rd_data_i`, the step wraps within eight bits, and `wr_data_o[15:8]` is 0. Selects 4 to 7 are 16-bit registers and use all sixteen bits.
- R8: For every legal operation `wr_en_o` is 1 with `done_o`, whether the branch is taken or not.
- R9: When the branch is not taken, `pc_next_o` equals the incoming PC.
- R10: `done_o` is 1 in the cycle after a cycle with `start_i` = 1 and 0 otherwise. `wr_en_o` is 0 whenever `done_o` is 0. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Execute one loop-branch step this cycle |
| postbyte_i | input | 8 | Packed step kind, branch sense, offset sign and register select |
| offset_i | input | 8 | Low eight bits of the branch displacement |
| pc_i | input | 16 | Program counter after operand fetch |
| rd_sel_o | output | 3 | Register-file read select |
| rd_data_i | input | 16 | Register-file read data |
| wr_en_o | output | 1 | Register-file write enable |
| wr_sel_o | output | 3 | Register-file write select |
| wr_data_o | output | 16 | Register-file write data |
| pc_next_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Illegal step kind |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench runs every one of the 256 postbytes, so every step kind (including the illegal one), both branch senses, both offset signs and all eight registers are tried. Each postbyte meets register contents chosen to sit on the edges of the arithmetic. The values 0x0000, 0x0001 and 0xFFFF make decrement, test and increment land on or next to zero. Values 0x00FF and 0x0100 separate an 8-bit result, which wraps and ignores the upper byte, from a 16-bit one. Two offset/PC pairs separate forward from backward targets, and one of them wraps through the 16-bit address limit.

// File: rtl/loop_branch_unit.sv
module loop_branch_unit #(
  parameter int PC_W   = 16,
  parameter int REG_W  = 16,
  parameter int NARROW = 8,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       postbyte_i,
  input  logic [7:0]       offset_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [SEL_W-1:0] rd_sel_o,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             wr_en_o,
  output logic [SEL_W-1:0] wr_sel_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic [PC_W-1:0]  pc_next_o,
  output logic             taken_o,
  output logic             illegal_o,
  output logic             done_o
);
  localparam int WIDE_MASK = REG_W - NARROW;

  logic [1:0]       step_kind;
  logic             want_nonzero;
  logic             narrow_reg;
  logic             bad_kind;
  logic [REG_W-1:0] delta;
  logic [REG_W-1:0] sum;
  logic [REG_W-1:0] result;
  logic             is_zero;
  logic             branch;
  logic [PC_W-1:0]  disp;
  logic [PC_W-1:0]  target;

  assign step_kind    = postbyte_i[7:6];
  assign want_nonzero = postbyte_i[5];
  assign rd_sel_o     = postbyte_i[SEL_W-1:0];
  assign narrow_reg   = ~postbyte_i[2];
  assign bad_kind     = (step_kind == 2'b11);

  always_comb begin
    unique case (step_kind)
      2'b00:   delta = '1;
      2'b10:   delta = REG_W'(1);
      default: delta = '0;
    endcase
  end

  assign sum    = rd_data_i + delta;
  assign result = narrow_reg ? {{WIDE_MASK{1'b0}}, sum[NARROW-1:0]} : sum;
  assign is_zero = (result == '0);
  assign branch  = ~bad_kind & (want_nonzero ? ~is_zero : is_zero);

  assign disp   = {{(PC_W-8){postbyte_i[4]}}, offset_i};
  assign target = pc_i + disp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_sel_o  <= '0;
      wr_data_o <= '0;
      pc_next_o <= '0;
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o  <= start_i;
      wr_en_o <= start_i & ~bad_kind;
      if (start_i) begin
        wr_sel_o  <= rd_sel_o;
        wr_data_o <= result;
        pc_next_o <= branch ? target : pc_i;
        taken_o   <= branch;
        illegal_o <= bad_kind;
      end
    end
  end
endmodule

// File: rtl/loop_branch_unit_checker.sv
module loop_branch_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [7:0]  postbyte_i,
  input logic [7:0]  offset_i,
  input logic [15:0] pc_i,
  input logic        wr_en_o,
  input logic [2:0]  wr_sel_o,
  input logic [15:0] wr_data_o,
  input logic [15:0] pc_next_o,
  input logic        taken_o,
  input logic        illegal_o,
  input logic        done_o
);
  assert_done_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !wr_en_o);
  assert_illegal_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && postbyte_i[7:6] == 2'b11 |=> illegal_o && !wr_en_o && !taken_o && pc_next_o == $past(pc_i));
  assert_always_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && postbyte_i[7:6] != 2'b11 |=> wr_en_o && wr_sel_o == $past(postbyte_i[2:0]));
  assert_fallthrough_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && postbyte_i[7:6] != 2'b11 |=> taken_o || pc_next_o == $past(pc_i));
  assert_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !taken_o || pc_next_o == $past(pc_i) + {{8{$past(postbyte_i[4])}}, $past(offset_i)});
  assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && wr_en_o && !wr_sel_o[2] |-> wr_data_o[15:8] == 8'h00);
  assert_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && wr_en_o |-> taken_o == ($past(postbyte_i[5]) ? (wr_data_o != 16'h0) : (wr_data_o == 16'h0)));
endmodule

bind loop_branch_unit loop_branch_unit_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .postbyte_i(postbyte_i),
  .offset_i(offset_i), .pc_i(pc_i), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
  .wr_data_o(wr_data_o), .pc_next_o(pc_next_o), .taken_o(taken_o),
  .illegal_o(illegal_o), .done_o(done_o)
);

// File: tb/loop_branch_unit_tb_top.sv
module loop_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  postbyte_i = '0;
  logic [7:0]  offset_i = '0;
  logic [15:0] pc_i = '0;
  logic [2:0]  rd_sel_o;
  logic [15:0] rd_data_i;
  logic        wr_en_o;
  logic [2:0]  wr_sel_o;
  logic [15:0] wr_data_o;
  logic [15:0] pc_next_o;
  logic        taken_o;
  logic        illegal_o;
  logic        done_o;
  logic [15:0] regs [8];

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign rd_data_i = regs[rd_sel_o];

  loop_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .postbyte_i(postbyte_i),
    .offset_i(offset_i), .pc_i(pc_i), .rd_sel_o(rd_sel_o), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o),
    .pc_next_o(pc_next_o), .taken_o(taken_o), .illegal_o(illegal_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] pb, input logic [7:0] off, input logic [15:0] pc, input logic [15:0] val);
    logic [1:0]  kind;
    logic [15:0] nv;
    logic [15:0] tgt;
    logic        narrow;
    logic        zero;
    logic        tk;
    string       rq;
    kind   = pb[7:6];
    narrow = (pb[2:0] < 3'd4);
    nv     = val;
    if (kind == 2'b00) nv = val - 16'd1;
    if (kind == 2'b10) nv = val + 16'd1;
    if (narrow) nv = nv & 16'h00FF;
    zero = (nv == 16'h0);
    tk   = (kind != 2'b11) && (pb[5] ? !zero : zero);
    tgt  = pc + (pb[4] ? (16'hFF00 | {8'h00, off}) : {8'h00, off});
    rq   = (kind == 2'b00) ? "R1" : (kind == 2'b01) ? "R2" : (kind == 2'b10) ? "R3" : "R4";
    for (int r = 0; r < 8; r++) regs[r] = 16'h5A5A;
    regs[pb[2:0]] = val;
    @(negedge clk);
    postbyte_i = pb; offset_i = off; pc_i = pc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R10", "done", {15'd0, done_o}, 16'd1);
    check("R4", "illegal", {15'd0, illegal_o}, {15'd0, kind == 2'b11});
    if (kind == 2'b11) begin
      check("R4", "wr_en", {15'd0, wr_en_o}, 16'd0);
      check("R4", "taken", {15'd0, taken_o}, 16'd0);
      check("R4", "pc_next", pc_next_o, pc);
    end else begin
      check("R8", "wr_en", {15'd0, wr_en_o}, 16'd1);
      check("R7", "wr_sel", {13'd0, wr_sel_o}, {13'd0, pb[2:0]});
      check(narrow ? "R7" : rq, "wr_data", wr_data_o, nv);
      check("R6", "taken", {15'd0, taken_o}, {15'd0, tk});
      if (tk) check("R5", "target", pc_next_o, tgt);
      else    check("R9", "fallthrough", pc_next_o, pc);
    end
    @(negedge clk);
    check("R10", "done_drop", {14'd0, done_o, wr_en_o}, 16'd0);
  endtask

  initial begin
    logic [15:0] vals [6];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF;
    vals[3] = 16'h00FF; vals[4] = 16'h0100; vals[5] = 16'h8001;
    for (int r = 0; r < 8; r++) regs[r] = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset done", {15'd0, done_o}, 16'd0);
    check("R10", "reset wr_en", {15'd0, wr_en_o}, 16'd0);
    check("R10", "reset pc_next", pc_next_o, 16'd0);
    check("R10", "reset illegal", {15'd0, illegal_o}, 16'd0);
    rst_n = 1'b1;
    for (int p = 0; p < 256; p++) begin
      for (int v = 0; v < 6; v++) begin
        run_one(8'(p), 8'h24, 16'h4000, vals[v]);
        run_one(8'(p), 8'hF0, 16'hFFF8, vals[v]);
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule